// File: doc/BRIEF.md
# SPI Master with Ratio Clock Divider

This block is a serial port that acts as an SPI master with a stopped clock between words. A ratio generator divides the reference clock by a programmable value and builds the serial clock from it. Odd ratios are supported, and even ratios give a defined uneven high/low split. A one-cycle start strobe captures a parallel transmit word and the divider value. The port then lowers an active-low select and shifts the word out most significant bit first. At the same time it assembles a received word from the input pin.

Every interval of a transfer is a whole number of reference cycles. This covers the lead-in before the first falling edge, the clock phases, the release of the data driver and the release of the select. The intervals derive from the high-phase length H and the period T of the serial clock. When the select returns high, a one-cycle done pulse marks the received word as valid. The data output has a separate drive-enable, which the surrounding pad logic uses as a tri-state control.

Top module: `spi_ratio_master`

## Requirements
- R1: With D equal to the divider value (a value of 0 is used as 1), the serial clock period is T = D+1 reference cycles. For even D the high phase lasts D/2+1 cycles and the low phase lasts D/2 cycles. For odd D both phases last (D+1)/2 cycles.
- R2: After reset and while idle, sclk_o is 1, ss_no is 1, mosi_oe_o is 0 and done_o is 0.
- R3: ss_no goes low in the cycle after a start strobe is accepted. The first falling edge of sclk_o comes H cycles after ss_no falls.
- R4: The transmit word leaves MSB first, bit WORD_W-1 down to bit 0. mosi_o changes only when sclk_o falls and holds through each whole clock period.
- R5: miso_i is sampled at each rising edge of sclk_o. The first sample is stored in rx_word_o bit WORD_W-1 and the last in bit 0.
- R6: A transfer produces exactly WORD_W falling and WORD_W rising edges of sclk_o.
- R7: mosi_oe_o is 1 from the fall of ss_no until H cycles after the last rising edge, then 0.
- R8: ss_no returns high T cycles after the last rising edge. done_o is 1 for exactly that first cycle, and rx_word_o then holds the received word.
- R9: A start strobe that arrives while a transfer is in progress is ignored. The word being sent, its timing and its divider do not change, and no second transfer follows.
- R10: A divider value of 0 produces the same waveform as a value of 1 (H = 1, L = 1, T = 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, one cycle, accepted only while idle |
| tx_word_i | input | WORD_W | Word to transmit, captured on start |
| div_i | input | DIV_W | Divider value D, captured on start |
| miso_i | input | 1 | Serial data from the slave |
| sclk_o | output | 1 | Serial clock, idles high |
| ss_no | output | 1 | Active-low slave select |
| mosi_o | output | 1 | Serial data to the slave |
| mosi_oe_o | output | 1 | Drive enable for mosi_o (0 means high impedance) |
| rx_word_o | output | WORD_W | Received word |
| done_o | output | 1 | One-cycle pulse when ss_no is released |

## Verification
The assertions assume that start_i lasts one cycle and that miso_i is stable in the reference cycle that ends each low phase of sclk_o. The bench changes miso_i only on the reference cycle in which it sees sclk_o fall, so every sample comes from a value held across the whole low phase. The divider and transmit word may change freely while busy. The bench does this deliberately, with a second strobe and a different divider mid-transfer, to show that the captured configuration stays fixed.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_TAIL
  } state_e;
endpackage

// File: rtl/spi_rm_phase.sv
// Derives the high and low phase lengths of the serial clock from the divider.
module spi_rm_phase #(
  parameter int DIV_W = 8
) (
  input  logic [DIV_W-1:0] div_i,
  output logic [DIV_W-1:0] high_len_o,
  output logic [DIV_W-1:0] low_len_o
);
  logic [DIV_W-1:0] d_eff;
  logic [DIV_W:0]   d_inc;

  always_comb begin
    d_eff = (div_i == '0) ? DIV_W'(1) : div_i;
    d_inc = {1'b0, d_eff} + 1'b1;
    if (d_eff[0]) begin
      high_len_o = d_inc[DIV_W:1];
      low_len_o  = d_inc[DIV_W:1];
    end else begin
      high_len_o = {1'b0, d_eff[DIV_W-1:1]} + 1'b1;
      low_len_o  = {1'b0, d_eff[DIV_W-1:1]};
    end
  end
endmodule

// File: rtl/spi_rm_shift.sv
// Transmit and receive shift registers, MSB first.
module spi_rm_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] tx_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [WORD_W-1:0] rx_o
);
  logic [WORD_W-1:0] tx_q;
  logic [WORD_W-1:0] rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
    end else if (load_i) begin
      tx_q <= tx_i;
    end else if (shift_i) begin
      tx_q <= {tx_q[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q <= '0;
    end else if (sample_i) begin
      rx_q <= {rx_q[WORD_W-2:0], miso_i};
    end
  end

  assign mosi_o = tx_q[WORD_W-1];
  assign rx_o   = rx_q;

  // R4: the transmit register moves only on load or on a falling-edge shift
  a_r4_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(load_i) && !$past(shift_i)) |-> $stable(tx_q));
endmodule

// File: rtl/spi_ratio_master.sv
module spi_ratio_master #(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              ss_no,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              done_o
);
  import spi_rm_pkg::*;

  localparam int BC_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;

  state_e           st_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] hlen_q, llen_q;
  logic [DIV_W-1:0] hlen_d, llen_d;
  logic [BC_W-1:0]  bit_q;
  logic             done_q;
  logic             load, shift, sample, cnt_end;

  spi_rm_phase #(.DIV_W(DIV_W)) u_phase (
    .div_i     (div_i),
    .high_len_o(hlen_d),
    .low_len_o (llen_d)
  );

  assign cnt_end = (cnt_q == '0);
  assign load    = (st_q == ST_IDLE) && start_i;
  assign sample  = (st_q == ST_LOW) && cnt_end;
  assign shift   = (st_q == ST_HIGH) && cnt_end && (bit_q != '0);

  spi_rm_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .tx_i    (tx_word_i),
    .shift_i (shift),
    .sample_i(sample),
    .miso_i  (miso_i),
    .mosi_o  (mosi_o),
    .rx_o    (rx_word_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      hlen_q <= DIV_W'(1);
      llen_q <= DIV_W'(1);
      bit_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          hlen_q <= hlen_d;
          llen_q <= llen_d;
          cnt_q  <= hlen_d - 1'b1;
          bit_q  <= BC_W'(WORD_W - 1);
          st_q   <= ST_LEAD;
        end
        ST_LEAD: if (cnt_end) begin
          cnt_q <= llen_q - 1'b1;
          st_q  <= ST_LOW;
        end else cnt_q <= cnt_q - 1'b1;
        ST_LOW: if (cnt_end) begin
          cnt_q <= hlen_q - 1'b1;
          st_q  <= ST_HIGH;
        end else cnt_q <= cnt_q - 1'b1;
        ST_HIGH: if (cnt_end) begin
          cnt_q <= llen_q - 1'b1;
          if (bit_q == '0) st_q <= ST_TAIL;
          else begin
            bit_q <= bit_q - 1'b1;
            st_q  <= ST_LOW;
          end
        end else cnt_q <= cnt_q - 1'b1;
        ST_TAIL: if (cnt_end) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sclk_o    = (st_q != ST_LOW);
  assign ss_no     = (st_q == ST_IDLE);
  assign mosi_oe_o = (st_q == ST_LEAD) || (st_q == ST_LOW) || (st_q == ST_HIGH);
  assign done_o    = done_q;

  // R2: clock parked high whenever the select is released
  a_r2_idle_clock_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_no |-> sclk_o);
  // R7: data driver only enabled inside a frame
  a_r7_oe_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mosi_oe_o |-> !ss_no);
  // R8: done coincides with the release of the select
  a_r8_done_on_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $rose(ss_no));
  // R9: captured phase lengths hold for the whole frame
  a_r9_cfg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ss_no && $past(!ss_no)) |-> ($stable(hlen_q) && $stable(llen_q)));
  // R1: low phase counter stays inside the low length
  a_r1_low_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOW) |-> (cnt_q < llen_q));
  // R4: data does not move while the clock stays high inside a frame
  a_r4_data_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ss_no && $past(!ss_no) && sclk_o && $past(sclk_o)) |-> $stable(mosi_o));
endmodule

// File: tb/tb_spi_ratio_master.sv
module tb_spi_ratio_master;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int DW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [W-1:0]  tx_word_i = '0;
  logic [DW-1:0] div_i = '0;
  logic          miso_i = 1'b0;
  logic          sclk_o, ss_no, mosi_o, mosi_oe_o, done_o;
  logic [W-1:0]  rx_word_o;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  spi_ratio_master #(.WORD_W(W), .DIV_W(DW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .tx_word_i(tx_word_i),
    .div_i(div_i), .miso_i(miso_i), .sclk_o(sclk_o), .ss_no(ss_no),
    .mosi_o(mosi_o), .mosi_oe_o(mosi_oe_o), .rx_word_o(rx_word_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_xfer(input int div, input logic [W-1:0] tx,
                          input logic [W-1:0] pat, input bit poke);
    int d, h, l, t, idx, falls, rises, run, first_fall, last_rise, oe_off, done_idx;
    int mis, run_bad, hold_bad;
    bit prev, cur_bit;
    d = (div == 0) ? 1 : div;
    h = (d % 2 == 0) ? d/2 + 1 : (d + 1)/2;
    l = d + 1 - h;
    t = d + 1;
    @(negedge clk_i);
    div_i = DW'(div); tx_word_i = tx; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(ss_no == 1'b0 && mosi_oe_o == 1'b1, "R3 select low after start", ss_no, 0);
    idx = 0; falls = 0; rises = 0; run = 0; prev = 1'b1;
    first_fall = -1; last_rise = -1; oe_off = -1; done_idx = -1;
    mis = 0; run_bad = 0; hold_bad = 0; cur_bit = tx[W-1];
    while (idx < 5000) begin
      if (!done_o && start_i) start_i = 1'b0;
      if (!sclk_o && prev) begin
        falls++;
        if (falls == 1) first_fall = idx;
        else if (run != h) run_bad++;
        run = 0;
        if (falls <= W) begin
          miso_i = pat[W-falls];
          cur_bit = tx[W-falls];
        end
        if (poke && falls == 2) begin
          start_i = 1'b1; tx_word_i = ~tx; div_i = DW'(div + 3);
        end
      end else if (sclk_o && !prev) begin
        rises++;
        if (run != l) run_bad++;
        last_rise = idx;
        run = 0;
      end
      if (mosi_oe_o && mosi_o != cur_bit) hold_bad++;
      if (!mosi_oe_o && oe_off < 0) oe_off = idx;
      if (done_o) begin
        done_idx = idx;
        break;
      end
      run++;
      prev = sclk_o;
      @(negedge clk_i);
      idx++;
    end
    start_i = 1'b0;
    if (hold_bad != 0) mis = hold_bad;
    chk(first_fall == h, "R3 first fall after H", first_fall, h);
    chk(run_bad == 0, (div == 0) ? "R10 phase lengths for zero divider" : "R1 phase lengths",
        run_bad, 0);
    chk(falls == W && rises == W, "R6 edge count", falls, W);
    chk(mis == 0, "R4 MSB-first data changing on fall", mis, 0);
    chk(oe_off == last_rise + h, "R7 driver release", oe_off, last_rise + h);
    chk(done_idx == last_rise + t && ss_no == 1'b1, "R8 select release and done",
        done_idx, last_rise + t);
    chk(rx_word_o == pat, "R5 received word", int'(rx_word_o), int'(pat));
    @(negedge clk_i);
    chk(done_o == 1'b0, "R8 done one cycle", done_o, 0);
    if (poke) begin
      repeat (3) @(negedge clk_i);
      chk(ss_no == 1'b1 && sclk_o == 1'b1, "R9 busy start ignored", ss_no, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(sclk_o && ss_no && !mosi_oe_o && !done_o, "R2 reset idle state",
        {sclk_o, ss_no, mosi_oe_o, done_o}, 4'b1100);
    for (int dv = 0; dv < 10; dv++) begin
      run_xfer(dv, 8'hA5, 8'h3C, 1'b0);
      run_xfer(dv, 8'h81, 8'hFE, dv % 2 == 1);
      run_xfer(dv, 8'h5A, 8'h01, dv % 3 == 0);
      chk(sclk_o && ss_no && !mosi_oe_o, "R2 idle between words",
          {sclk_o, ss_no, mosi_oe_o}, 3'b110);
    end
    run_xfer(255, 8'hC3, 8'h96, 1'b1);
    run_xfer(254, 8'h0F, 8'hF0, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule